// File: doc/BRIEF.md
# Speculative Return Address Predictor

The block predicts the target of subroutine returns while the front end runs ahead of commit. It pairs a 32-slot backing stack of return addresses with a small ordered queue of speculative push and pop actions. A call pushes its return address and a return pops one. Neither action writes the backing stack directly. Each action is stored with the bundle tag that produced it and with the stack pointer value it leaves behind. A push is keyed by the slot it occupies.

The predicted address is found by searching the queue from newest to oldest for a push whose key equals the current stack pointer. If no push matches, the backing stack slot at the pointer supplies the address. On a mispredict, every queued action from a younger bundle is discarded and the pointer is rewound. Committed actions drain from the queue head into the backing stack, one per clock. A wrong path can move the pointer but can never overwrite stack contents that a correct path still needs.

Top module: `ret_stack_spec`

## Requirements
- R1: After reset the stack pointer is 0, the queue is empty, every backing slot holds 0, and the predicted address is 0.
- R2: An accepted call moves the stack pointer to pointer+1 (mod 32) and queues a push keyed by that new value. From the next cycle the prediction is the call's address.
- R3: An accepted return moves the pointer to pointer-1 (mod 32) and queues a pop. The pointer wraps from 31 to 0 and from 0 to 31, so an overflow overwrites the oldest slot.
- R4: The prediction is the address of the newest queued push whose key equals the current pointer. If no queued push matches, the prediction is the backing slot indexed by the pointer.
- R5: When a call and a return arrive in the same cycle, only the call is taken.
- R6: A flush with tag F removes every queued action whose tag T satisfies 1 <= (T-F) mod 16 <= 7. Call and return inputs are ignored in that cycle. The pointer becomes the post-action pointer of the newest retained action, or the committed pointer if nothing is retained.
- R7: A commit with tag C marks all queued actions tagged C. From the next cycle, a marked head action leaves the queue, one per clock. A drained push writes its address into the backing slot at its key. Every drained action sets the committed pointer to its post-action value.
- R8: The queue holds 8 actions. A call or return that arrives when 8 actions are held at the start of the cycle is dropped, and the pointer is unchanged.
- R9: A flush that discards a wrong-path return followed by a call restores the prediction to the return address pushed before the branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Call seen: push request |
| call_addr_i | input | 32 | Return address to push |
| ret_i | input | 1 | Return seen: pop request |
| act_tag_i | input | 4 | Bundle tag of the call or return |
| flush_i | input | 1 | Mispredict: discard younger actions |
| flush_tag_i | input | 4 | Tag of the mispredicted bundle |
| commit_i | input | 1 | Bundle committed |
| commit_tag_i | input | 4 | Tag of the committed bundle |
| pred_addr_o | output | 32 | Predicted return address |
| tos_o | output | 5 | Current speculative stack pointer |

## Verification
Directed sequences cover each case in turn. Plain call chains and single returns check the pointer arithmetic. A simultaneous call and return confirms which one is taken. A full queue followed by a ninth call exposes the drop rule. Thirty-odd committed calls wrap the pointer past 31. A return and call on a wrong path, then flushed, separates a stack that keeps its contents from one that a speculative overwrite corrupts. Commit-then-drain sequences show that the fallback slot holds the drained address. A long random mix of calls, returns, commits and flushes is compared every clock against a behavioural queue model. This mix catches errors in the age rule, the rewind value and the override order between pushes that share a key.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  parameter int RA_W = 32;              // return address width
  parameter int SP_W = 5;               // stack pointer width
  parameter int BT_W = 4;               // bundle tag width
  parameter int QD   = 8;               // speculative queue depth
  localparam int QP_W = $clog2(QD);
  localparam int SD   = 1 << SP_W;      // backing stack depth

  typedef struct packed {
    logic            is_push;
    logic [SP_W-1:0] tos_after;         // pointer after the action (key for pushes)
    logic [RA_W-1:0] addr;
    logic [BT_W-1:0] tag;
    logic            done;              // committed
  } rsq_ent_t;

  function automatic logic [SP_W-1:0] sp_step(input logic [SP_W-1:0] p, input logic up);
    return up ? p + 1'b1 : p - 1'b1;
  endfunction

  // tag t belongs to a bundle younger than ref_t (wrap-aware, half window)
  function automatic logic tag_after(input logic [BT_W-1:0] t, input logic [BT_W-1:0] ref_t);
    logic [BT_W-1:0] d;
    d = t - ref_t;
    return (d != '0) && !d[BT_W-1];
  endfunction
endpackage

// File: rtl/rsq_backing.sv
module rsq_backing
  import rsq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_push,
  input  logic [SP_W-1:0] wr_tos,
  input  logic [RA_W-1:0] wr_addr,
  input  logic [SP_W-1:0] rd_idx,
  output logic [RA_W-1:0] rd_data,
  output logic [SP_W-1:0] ctos
);
  logic [RA_W-1:0] mem [SD];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SD; i++) mem[i] <= '0;
      ctos <= '0;
    end else if (wr_en) begin
      ctos <= wr_tos;
      if (wr_push) mem[wr_tos] <= wr_addr;
    end
  end

  assign rd_data = mem[rd_idx];

  // R7: a drained action leaves the committed pointer at its post-action value
  a_r7_ctos_follows: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctos == $past(wr_tos));
endmodule

// File: rtl/rsq_queue.sv
module rsq_queue
  import rsq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            app_en,
  input  rsq_ent_t        app_ent,
  input  logic            flush_en,
  input  logic [BT_W-1:0] flush_tag,
  input  logic            commit_en,
  input  logic [BT_W-1:0] commit_tag,
  input  logic [SP_W-1:0] look_key,
  output logic            look_hit,
  output logic [RA_W-1:0] look_addr,
  output logic            full,
  output logic            drain_en,
  output rsq_ent_t        drain_ent,
  output logic            restore_ok,
  output logic [SP_W-1:0] restore_tos
);
  rsq_ent_t          ent [QD];
  logic [QP_W-1:0]   head;
  logic [QP_W:0]     cnt;
  logic [QP_W:0]     keep;
  logic [QP_W:0]     base;
  logic [QP_W-1:0]   ridx;
  logic              found;

  assign full = (cnt == (QP_W+1)'(QD));

  // truncation point: first entry belonging to a younger bundle
  always_comb begin
    keep  = cnt;
    found = 1'b0;
    for (int i = 0; i < QD; i++) begin
      if (!found && (QP_W+1)'(i) < cnt &&
          tag_after(ent[head + QP_W'(i)].tag, flush_tag)) begin
        keep  = (QP_W+1)'(i);
        found = 1'b1;
      end
    end
  end

  assign restore_ok  = flush_en && (keep != '0);
  assign ridx        = head + QP_W'(keep - 1'b1);
  assign restore_tos = ent[ridx].tos_after;

  assign drain_ent = ent[head];
  assign drain_en  = (cnt != '0) && ent[head].done && !(flush_en && keep == '0);

  // newest matching push wins: later iterations override earlier ones
  always_comb begin
    look_hit  = 1'b0;
    look_addr = '0;
    for (int i = 0; i < QD; i++) begin
      if ((QP_W+1)'(i) < cnt && ent[head + QP_W'(i)].is_push &&
          ent[head + QP_W'(i)].tos_after == look_key) begin
        look_hit  = 1'b1;
        look_addr = ent[head + QP_W'(i)].addr;
      end
    end
  end

  assign base = flush_en ? keep : cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      cnt  <= '0;
      for (int i = 0; i < QD; i++) ent[i] <= '0;
    end else begin
      for (int i = 0; i < QD; i++)
        if (commit_en && ent[i].tag == commit_tag) ent[i].done <= 1'b1;
      if (app_en) ent[head + QP_W'(base)] <= app_ent;
      if (drain_en) head <= head + 1'b1;
      cnt <= base - (QP_W+1)'(drain_en) + (QP_W+1)'(app_en);
    end
  end

  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (QP_W+1)'(QD));
  a_r6_flush_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    flush_en |=> cnt <= $past(cnt));
  a_r7_drain_single: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_en && !flush_en && !app_en) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/ret_stack_spec.sv
module ret_stack_spec
  import rsq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            call_i,
  input  logic [RA_W-1:0] call_addr_i,
  input  logic            ret_i,
  input  logic [BT_W-1:0] act_tag_i,
  input  logic            flush_i,
  input  logic [BT_W-1:0] flush_tag_i,
  input  logic            commit_i,
  input  logic [BT_W-1:0] commit_tag_i,
  output logic [RA_W-1:0] pred_addr_o,
  output logic [SP_W-1:0] tos_o
);
  logic [SP_W-1:0] tos, tos_nx, ctos, ctos_nx, restore_tos;
  logic            q_full, push_ok, pop_ok, look_hit, drain_en, restore_ok;
  logic [RA_W-1:0] look_addr, stk_top;
  rsq_ent_t        app_ent, drain_ent;

  // named events for assertions
  assign push_ok = call_i && !flush_i && !q_full;
  assign pop_ok  = ret_i && !call_i && !flush_i && !q_full;

  always_comb begin
    app_ent           = '0;
    app_ent.is_push   = push_ok;
    app_ent.tos_after = sp_step(tos, push_ok);
    app_ent.addr      = call_addr_i;
    app_ent.tag       = act_tag_i;
  end

  assign ctos_nx = drain_en ? drain_ent.tos_after : ctos;

  always_comb begin
    if (flush_i)      tos_nx = restore_ok ? restore_tos : ctos_nx;
    else if (push_ok) tos_nx = sp_step(tos, 1'b1);
    else if (pop_ok)  tos_nx = sp_step(tos, 1'b0);
    else              tos_nx = tos;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tos <= '0;
    else        tos <= tos_nx;
  end

  rsq_queue u_queue (
    .clk(clk), .rst_n(rst_n),
    .app_en(push_ok || pop_ok), .app_ent(app_ent),
    .flush_en(flush_i), .flush_tag(flush_tag_i),
    .commit_en(commit_i), .commit_tag(commit_tag_i),
    .look_key(tos), .look_hit(look_hit), .look_addr(look_addr),
    .full(q_full), .drain_en(drain_en), .drain_ent(drain_ent),
    .restore_ok(restore_ok), .restore_tos(restore_tos)
  );

  rsq_backing u_stack (
    .clk(clk), .rst_n(rst_n),
    .wr_en(drain_en), .wr_push(drain_ent.is_push),
    .wr_tos(drain_ent.tos_after), .wr_addr(drain_ent.addr),
    .rd_idx(tos), .rd_data(stk_top), .ctos(ctos)
  );

  assign pred_addr_o = look_hit ? look_addr : stk_top;
  assign tos_o       = tos;

  a_r2_push_tos: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> tos == $past(tos) + 1'b1);
  a_r3_pop_tos: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> tos == $past(tos) - 1'b1);
  a_r2_push_visible: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> pred_addr_o == $past(call_addr_i));
  a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && !flush_i && (call_i || ret_i)) |=> tos == $past(tos));
  a_r5_call_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && ret_i && !flush_i && !q_full) |=> tos == $past(tos) + 1'b1);
endmodule

// File: tb/ret_stack_spec_test.sv
`timescale 1ns/1ps
module ret_stack_spec_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        call_i, ret_i, flush_i, commit_i;
  logic [31:0] call_addr_i;
  logic [3:0]  act_tag_i, flush_tag_i, commit_tag_i;
  logic [31:0] pred_addr_o;
  logic [4:0]  tos_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ret_stack_spec uut (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .call_addr_i(call_addr_i),
    .ret_i(ret_i), .act_tag_i(act_tag_i), .flush_i(flush_i),
    .flush_tag_i(flush_tag_i), .commit_i(commit_i), .commit_tag_i(commit_tag_i),
    .pred_addr_o(pred_addr_o), .tos_o(tos_o)
  );

  // behavioural reference model
  typedef struct {
    bit          push;
    int          after;
    logic [31:0] addr;
    int          tag;
    bit          done;
  } ment_t;
  ment_t       mq[$];
  logic [31:0] mstack [32];
  int          mtos, mctos;

  function automatic bit younger(int t, int f);
    int d;
    d = (t - f + 16) % 16;
    return d >= 1 && d <= 7;
  endfunction

  function automatic logic [31:0] exp_pred();
    for (int i = mq.size() - 1; i >= 0; i--)
      if (mq[i].push && mq[i].after == mtos) return mq[i].addr;
    return mstack[mtos];
  endfunction

  task automatic model(bit c, bit r, logic [31:0] a, int t, bit f, int ft, bit cm, int ct);
    int    n, keep;
    bit    drn, acc;
    ment_t e;
    n = mq.size();
    drn = n > 0 && mq[0].done;
    keep = n;
    if (f) begin
      for (int i = n - 1; i >= 0; i--) if (younger(mq[i].tag, ft)) keep = i;
      if (keep == 0) drn = 0;
    end
    acc = !f && n < 8;
    if (f) while (mq.size() > keep) void'(mq.pop_back());
    if (drn) begin
      e = mq.pop_front();
      mctos = e.after;
      if (e.push) mstack[e.after] = e.addr;
    end
    if (f) mtos = (mq.size() > 0) ? mq[mq.size()-1].after : mctos;
    if (cm) foreach (mq[i]) if (mq[i].tag == ct) mq[i].done = 1;
    if (acc && c) begin
      mtos = (mtos + 1) % 32;
      e = '{push: 1, after: mtos, addr: a, tag: t, done: 0};
      mq.push_back(e);
    end else if (acc && r) begin
      mtos = (mtos + 31) % 32;
      e = '{push: 0, after: mtos, addr: 0, tag: t, done: 0};
      mq.push_back(e);
    end
  endtask

  task automatic compare(string req);
    logic [31:0] ep;
    ep = exp_pred();
    checks++;
    if (pred_addr_o !== ep) begin
      errors++;
      $display("FAIL %s pred_addr actual=%h expected=%h", req, pred_addr_o, ep);
    end
    checks++;
    if (tos_o !== 5'(mtos)) begin
      errors++;
      $display("FAIL %s tos actual=%0d expected=%0d", req, tos_o, mtos);
    end
  endtask

  task automatic step(bit c, bit r, logic [31:0] a, int t, bit f, int ft,
                      bit cm, int ct, string req);
    @(negedge clk);
    call_i = c; ret_i = r; call_addr_i = a; act_tag_i = 4'(t);
    flush_i = f; flush_tag_i = 4'(ft); commit_i = cm; commit_tag_i = 4'(ct);
    @(posedge clk);
    model(c, r, a, t & 15, f, ft & 15, cm, ct & 15);
    #1;
    compare(req);
  endtask

  task automatic idle(int k, string req);
    for (int i = 0; i < k; i++) step(0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cur;
    for (int i = 0; i < 32; i++) mstack[i] = '0;
    mtos = 0; mctos = 0;
    rst_n = 1'b0; call_i = 0; ret_i = 0; call_addr_i = 0; act_tag_i = 0;
    flush_i = 0; flush_tag_i = 0; commit_i = 0; commit_tag_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1 compare("R1");                                   // reset state

    step(1, 0, 32'h1000, 1, 0, 0, 0, 0, "R2");
    step(1, 0, 32'h2000, 2, 0, 0, 0, 0, "R2");
    step(1, 0, 32'h3000, 3, 0, 0, 0, 0, "R2");
    step(0, 1, 0,        4, 0, 0, 0, 0, "R3");         // pop back to 0x2000
    step(1, 1, 32'h4000, 4, 0, 0, 0, 0, "R5");         // call wins
    step(0, 0, 0, 0, 0, 0, 1, 1, "R7");
    step(0, 0, 0, 0, 0, 0, 1, 2, "R7");
    step(0, 0, 0, 0, 0, 0, 1, 3, "R7");
    step(0, 0, 0, 0, 0, 0, 1, 4, "R7");
    idle(6, "R7");                                      // falls back to drained stack

    // wrong path: call, branch, return + call, then flush on the branch bundle
    step(1, 0, 32'hA100, 5, 0, 0, 0, 0, "R9");
    step(0, 0, 0,        6, 0, 0, 0, 0, "R9");
    step(0, 1, 0,        7, 0, 0, 0, 0, "R9");
    step(1, 0, 32'hB200, 7, 0, 0, 0, 0, "R4");         // overrides same key
    step(0, 0, 0, 0, 1, 6, 0, 0, "R9");                // restore A100
    step(0, 0, 0, 0, 0, 0, 1, 5, "R7");
    idle(3, "R7");

    // fill the queue and overflow it
    for (int i = 0; i < 9; i++) step(1, 0, 32'hC000 + i, 8, 0, 0, 0, 0, "R8");
    step(0, 1, 0, 8, 0, 0, 0, 0, "R8");
    step(1, 1, 32'hDEAD, 8, 1, 7, 0, 0, "R6");         // empty after flush
    idle(2, "R6");

    // wrap the pointer past 31 and below 0
    for (int k = 0; k < 30; k++) begin
      step(1, 0, 32'hE000 + k, (9 + k) % 16, 0, 0, 0, 0, "R3");
      step(0, 0, 0, 0, 0, 0, 1, (9 + k) % 16, "R3");
    end
    idle(3, "R3");
    for (int k = 0; k < 4; k++) begin
      step(0, 1, 0, k, 0, 0, 0, 0, "R3");
      step(0, 0, 0, 0, 0, 0, 1, k, "R3");
    end
    idle(3, "R3");

    // random mix
    cur = 4;
    for (int k = 0; k < 600; k++) begin
      bit c, r, f, cm;
      c  = ($urandom % 3) == 0;
      r  = ($urandom % 3) == 0;
      f  = ($urandom % 14) == 0;
      cm = ($urandom % 2) == 0;
      step(c, r, $urandom, cur, f, (cur - int'($urandom % 3) + 16) % 16,
           cm, (cur - 1 - int'($urandom % 3) + 16) % 16, "R4");
      if ($urandom % 2) cur = (cur + 1) % 16;
    end
    idle(10, "R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule